// File: doc/BRIEF.md
# Low-Voltage Detect Status and Interrupt Register

This block is the digital side of a supply low-voltage detector. A comparator elsewhere on the chip reports whether the supply has fallen below its trip level. Its assert and release levels differ, which gives hysteresis. That raw indication arrives asynchronously. The block synchronizes it and gates it with the current power mode. The result is a status bit that can only read high while the device runs at full performance.

Any change of that status, up or down, latches a sticky flag. Software clears the flag by writing a one to its bit. An interrupt request is driven while both the flag and its enable are set.

Software sees one 8-bit register on a simple select/read/write bus. Reads are combinational while the select and read strobe are high. Writes land on the next rising clock edge. Moving into a low-power mode pulls the status low, and that change sets the flag like any other change. Nothing in the block clears the flag because of a mode change.

Top module: `lvd_irq_reg`

## Requirements
- R1: A synchronous active-high reset clears the enable, the flag, the status and the synchronizer stages, so a read returns 0x00 and `irq` is 0.
- R2: The register layout is: bit 2 is the status, bit 1 is the interrupt enable and bit 0 is the flag. Bits 7 to 3 always read 0. `rdata` is 0x00 unless `sel` and `rd` are both high.
- R3: The status bit and bits 7 to 3 are read-only. Writing ones to them changes nothing that a read returns.
- R4: The status is 1 only when the synchronized detector input is 1 and `pwr_mode` is 2'b00 (full performance). Reduced power (2'b01), shutdown (2'b10) and the spare code 2'b11 all force it to 0.
- R5: A change on `det_raw` reaches the status and the flag on the third rising edge after it is applied. A change on `pwr_mode` reaches them on the first rising edge.
- R6: The flag becomes 1 on every edge where the status changes value, in either direction, and this includes changes caused by entering a low-power mode.
- R7: The flag is cleared only by a write (`sel` and `wr` high) with `wdata[0]`=1. A write with `wdata[0]`=0 leaves the flag unchanged.
- R8: If a status change and a clearing write fall on the same edge, the flag ends up 1.
- R9: The enable bit takes `wdata[1]` on each write and holds its value between writes.
- R10: `irq` is 1 exactly when the flag and the enable are both 1. It is valid in the same cycle as the register bits it depends on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| det_raw | input | 1 | Asynchronous comparator output, 1 when the supply is below its trip level |
| pwr_mode | input | 2 | Power mode: 00 full, 01 reduced, 10 shutdown, 11 spare |
| sel | input | 1 | Register select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The checker assumes that `pwr_mode` and the bus strobes are synchronous to `clk` and stable around each edge. `det_raw` is the only input allowed to move freely. The bench therefore changes every input only at falling edges. It holds `det_raw` steady for longer than the synchronizer depth before it samples, so that each expected status value follows one clear transition. The same-edge set-and-clear case is built by changing `pwr_mode` together with a clearing write. A mode change takes effect at a known edge, so the collision time is exact.

// File: rtl/lvd_pkg.sv
`timescale 1ns/1ps
package lvd_pkg;
  localparam int REG_W    = 8;
  localparam int BIT_FLAG = 0;
  localparam int BIT_EN   = 1;
  localparam int BIT_STAT = 2;

  typedef enum logic [1:0] {
    PM_FULL     = 2'b00,
    PM_REDUCED  = 2'b01,
    PM_SHUTDOWN = 2'b10,
    PM_SPARE    = 2'b11
  } pwr_mode_e;
endpackage

// File: rtl/lvd_sync.sv
`timescale 1ns/1ps
module lvd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= 1'b0;
      else     chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lvd_status.sv
`timescale 1ns/1ps
module lvd_status
  import lvd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       det_sync,
  input  logic [1:0] pwr_mode,
  output logic       status_q,
  output logic       changed
);
  logic full_perf;
  logic status_n;

  // Only full-performance mode lets the detector through.
  assign full_perf = (pwr_mode == PM_FULL);
  assign status_n  = det_sync & full_perf;
  assign changed   = (status_n != status_q);

  always_ff @(posedge clk) begin
    if (rst) status_q <= 1'b0;
    else     status_q <= status_n;
  end
endmodule

// File: rtl/lvd_regs.sv
`timescale 1ns/1ps
module lvd_regs
  import lvd_pkg::*;
#(
  parameter int DATA_W = REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              status_q,
  input  logic              changed,
  output logic [DATA_W-1:0] rdata,
  output logic              en_q,
  output logic              flag_q,
  output logic              irq
);
  logic wr_hit;
  logic rd_hit;
  logic flag_n;
  logic en_n;
  logic unused_wbits;

  assign wr_hit = sel & wr;
  assign rd_hit = sel & rd;

  // A status change wins over a clearing write on the same edge.
  always_comb begin
    flag_n = flag_q;
    if (changed)                        flag_n = 1'b1;
    else if (wr_hit && wdata[BIT_FLAG]) flag_n = 1'b0;
  end

  assign en_n = wr_hit ? wdata[BIT_EN] : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      en_q   <= 1'b0;
      irq    <= 1'b0;
    end else begin
      flag_q <= flag_n;
      en_q   <= en_n;
      irq    <= flag_n & en_n;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_hit) begin
      rdata[BIT_STAT] = status_q;
      rdata[BIT_EN]   = en_q;
      rdata[BIT_FLAG] = flag_q;
    end
  end

  assign unused_wbits = ^{wdata[DATA_W-1:BIT_STAT]};
endmodule

// File: rtl/lvd_irq_reg.sv
`timescale 1ns/1ps
module lvd_irq_reg
  import lvd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              det_raw,
  input  logic [1:0]        pwr_mode,
  input  logic              sel,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic det_sync;
  logic status_q;
  logic changed;
  logic en_q;
  logic flag_q;

  lvd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (det_raw),
    .q   (det_sync)
  );

  lvd_status u_status (
    .clk      (clk),
    .rst      (rst),
    .det_sync (det_sync),
    .pwr_mode (pwr_mode),
    .status_q (status_q),
    .changed  (changed)
  );

  lvd_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .rd       (rd),
    .wr       (wr),
    .wdata    (wdata),
    .status_q (status_q),
    .changed  (changed),
    .rdata    (rdata),
    .en_q     (en_q),
    .flag_q   (flag_q),
    .irq      (irq)
  );
endmodule

// File: rtl/lvd_irq_chk.sv
`timescale 1ns/1ps
module lvd_irq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        pwr_mode,
  input logic              sel,
  input logic              rd,
  input logic              wr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              irq,
  input logic              status_q,
  input logic              flag_q,
  input logic              en_q
);
  AST_RESET_IRQ_LOW: assert property (@(posedge clk) rst |=> !irq); // R1
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst) rdata[DATA_W-1:3] == '0); // R2
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst) !(sel && rd) |-> rdata == '0); // R2
  AST_STATUS_GATED: assert property (@(posedge clk) disable iff (rst) (pwr_mode != 2'b00) |=> !status_q); // R4
  AST_FLAG_ON_CHANGE: assert property (@(posedge clk) disable iff (rst) (status_q != $past(status_q)) |-> flag_q); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst) (flag_q && !(sel && wr && wdata[0])) |=> flag_q); // R7
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst) !(sel && wr) |=> $stable(en_q)); // R9
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst) (sel && rd) |-> (irq == (rdata[1] & rdata[0]))); // R10
endmodule

bind lvd_irq_reg lvd_irq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pwr_mode (pwr_mode),
  .sel      (sel),
  .rd       (rd),
  .wr       (wr),
  .wdata    (wdata),
  .rdata    (rdata),
  .irq      (irq),
  .status_q (status_q),
  .flag_q   (flag_q),
  .en_q     (en_q)
);

// File: tb/lvd_irq_reg_test.sv
`timescale 1ns/1ps
module lvd_irq_reg_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       det_raw = 1'b0;
  logic [1:0] pwr_mode = 2'b00;
  logic       sel = 1'b0;
  logic       rd = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] exp_data;
    logic       exp_irq;
    string      tag;
  } exp_item_t;

  exp_item_t exp_q[$];
  event      mon_ev;

  always #2.5 clk = ~clk;

  lvd_irq_reg uut (
    .clk      (clk),
    .rst      (rst),
    .det_raw  (det_raw),
    .pwr_mode (pwr_mode),
    .sel      (sel),
    .rd       (rd),
    .wr       (wr),
    .wdata    (wdata),
    .rdata    (rdata),
    .irq      (irq)
  );

  // Monitor: pops one expectation per read and compares.
  always @(mon_ev) begin
    exp_item_t it;
    #0.5;
    it = exp_q.pop_front();
    checks++;
    if (rdata !== it.exp_data || irq !== it.exp_irq) begin
      failures++;
      $display("FAIL %s rdata=%02h irq=%0b expected rdata=%02h irq=%0b",
               it.tag, rdata, irq, it.exp_data, it.exp_irq);
    end
  end

  // Driver: called at a falling edge; read completes before the next rising edge.
  task automatic do_read(input logic [7:0] e, input logic ei, input string tag);
    exp_item_t it;
    it.exp_data = e;
    it.exp_irq  = ei;
    it.tag      = tag;
    exp_q.push_back(it);
    sel = 1'b1;
    rd  = 1'b1;
    -> mon_ev;
    #1;
    sel = 1'b0;
    rd  = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] d);
    sel   = 1'b1;
    wr    = 1'b1;
    wdata = d;
    @(negedge clk);
    sel   = 1'b0;
    wr    = 1'b0;
    wdata = 8'h00;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #500000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired before the sequence ended");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    do_read(8'h00, 1'b0, "R1 reset state");

    // R2 idle bus reads zero
    sel = 1'b1; rd = 1'b0; #0.5;
    checks++;
    if (rdata !== 8'h00) begin
      failures++;
      $display("FAIL R2 idle rdata=%02h expected 00", rdata);
    end
    sel = 1'b0;
    tick(1);

    do_write(8'hFF);
    do_read(8'h02, 1'b0, "R3 R9 write FF sets only enable");

    // R5 latency of the detector path
    det_raw = 1'b1;
    do_read(8'h02, 1'b0, "R5 no change before first edge");
    tick(1);
    do_read(8'h02, 1'b0, "R5 no change after one edge");
    tick(1);
    do_read(8'h02, 1'b0, "R5 no change after two edges");
    tick(1);
    do_read(8'h07, 1'b1, "R5 R6 R10 rise after three edges");

    do_write(8'h02);
    do_read(8'h07, 1'b1, "R7 writing zero keeps flag");
    do_write(8'h03);
    do_read(8'h06, 1'b0, "R7 writing one clears flag");

    det_raw = 1'b0;
    tick(3);
    do_read(8'h03, 1'b1, "R6 falling status sets flag");

    do_write(8'h01);
    do_read(8'h00, 1'b0, "R9 enable cleared, flag cleared");
    det_raw = 1'b1;
    tick(3);
    do_read(8'h05, 1'b0, "R10 flag without enable gives no irq");
    do_write(8'h02);
    do_read(8'h07, 1'b1, "R9 R10 enable set raises irq");

    do_write(8'h03);
    do_read(8'h06, 1'b0, "R7 clear before mode test");
    pwr_mode = 2'b01;
    tick(1);
    do_read(8'h03, 1'b1, "R4 R6 reduced mode drops status and keeps flag");
    do_write(8'h03);
    do_read(8'h02, 1'b0, "R7 clear in reduced mode");
    tick(2);
    do_read(8'h02, 1'b0, "R4 reduced mode holds status low");
    pwr_mode = 2'b10;
    tick(1);
    do_read(8'h02, 1'b0, "R4 shutdown mode holds status low");
    pwr_mode = 2'b00;
    tick(1);
    do_read(8'h07, 1'b1, "R4 R5 full mode restores status one edge later");
    pwr_mode = 2'b11;
    tick(1);
    do_read(8'h03, 1'b1, "R4 spare code gates status");
    do_write(8'h03);
    pwr_mode = 2'b00;
    tick(1);
    do_read(8'h07, 1'b1, "R4 back to full mode");
    do_write(8'h03);
    do_read(8'h06, 1'b0, "R7 clear before collision");

    // R8 set and clear on the same edge
    pwr_mode = 2'b01;
    do_write(8'h03);
    do_read(8'h03, 1'b1, "R8 set wins over clear");

    rst = 1'b1;
    tick(1);
    rst = 1'b0;
    do_read(8'h00, 1'b0, "R1 reset mid-run");

    tick(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule